// File: doc/BRIEF.md
# Serial Management Register Slave

This block is the device-side end of a two-wire serial management bus. A station manager clocks frames on the management clock and moves a single data line that the block both samples and, during reads, drives. The block listens continuously, recognises frames meant for its own 5-bit bus address, and serves reads and writes to five 16-bit registers. These are a control word, a status word, two identifier words and an extended control word. The block never starts a transfer by itself. Every exchange is opened by the manager.

The bus address is taken from strap inputs once reset has been released, and it can be read back inside the extended control word. Address zero makes the device come up isolated. The identifier words are protected by an override bit. Two status bits capture event pulses and hold them until the manager has read the status word out completely. A self-clearing bit in the control word returns the writable state to its defaults.

The block runs entirely on the management clock. Its control outputs feed the rest of the device, and the event pulses come from link-side logic outside this block.

Top module: `mdio_mgmt_slave`

The frame decoder is a state machine with these states:

- ST_PRE counts consecutive ones.
- ST_START expects the second start bit.
- ST_OP collects the two opcode bits.
- ST_ADDR collects the device and register address.
- ST_TA covers the turnaround.
- ST_WDATA shifts in write data.
- ST_RDATA shifts out read data.

Its transitions are:

- ST_PRE→ST_START on a zero after at least PRE_LEN ones.
- ST_PRE→ST_PRE on a zero after a short run, which restarts the count.
- ST_START→ST_OP on a one, and ST_START→ST_PRE on a zero.
- ST_OP→ST_ADDR on a valid opcode, and ST_OP→ST_PRE on an invalid one.
- ST_ADDR→ST_TA on an address match, and ST_ADDR→ST_PRE on a mismatch.
- ST_TA→ST_RDATA for a read and ST_TA→ST_WDATA for a write.
- ST_WDATA→ST_PRE and ST_RDATA→ST_PRE after 16 bits.

## Requirements
- R1: A frame is acted on only when its 5-bit device address equals the captured bus address. For any other address the block does not enable its driver and changes no register.
- R2: The data line is sampled on each rising clock edge. A valid frame is at least 32 ones, then start bits 0,1, then an opcode of 1,0 (read) or 0,1 (write), then the device address and the register address (5 bits each, MSB first), then 2 turnaround bits, then 16 data bits MSB first.
- R3: A frame with a start of 0,0, an opcode of 0,0 or 1,1, or fewer than 32 leading ones is ignored. The block then needs a fresh run of 32 ones before it accepts another frame.
- R4: During a read the driver stays off through both turnaround bits. It then drives the 16 register bits MSB first, one per clock period, beginning in the period right after the turnaround. It releases the line in the period after the last bit.
- R5: On the first clock edge after reset release, the strap value becomes the bus address. It reads back in bits 10:6 of register 16 and is unaffected by writes.
- R6: Control register 0 resets to 0x3000 (bit 13 speed, bit 12 auto-negotiation enable). Bit 10 (isolate) is one exactly when the captured address is 00000.
- R7: Registers 2 and 3 always read their identifier values. A write to them takes effect only while bit 15 of register 16 (override) is one.
- R8: Bits not implemented read as zero, and writes to them have no effect. This covers bits 7:0 and 15 of register 0, all of register 1 except its status bits, bits 14:11, 5:4 and 2:0 of register 16, and every other register address.
- R9: Register 1 reads as 0x7809 with no events pending. An event pulse on the jabber input sets bit 1, and one on the remote-fault input sets bit 4. A set bit stays one until a read of register 1 has shifted out its last bit, and then it clears.
- R10: An event arriving while register 1 is being read leaves its bit set after that read completes.
- R11: Writing register 0 with bit 15 set restores the defaults of registers 0, 2, 3 and the writable bits of 16, and clears pending status bits. The captured address is kept. Bit 15 always reads as zero, including after a hardware reset.
- R12: The control outputs `ctrl_word` and `xctrl_word` always equal the read values of registers 0 and 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 5 | Bus address straps, captured after reset release |
| mdio_i | input | 1 | Sampled value of the management data line |
| mdio_o | output | 1 | Value driven onto the data line during read data |
| mdio_oe | output | 1 | Driver enable for the data line |
| ev_jabber | input | 1 | Jabber event pulse, latched into status bit 1 |
| ev_remote_fault | input | 1 | Remote-fault event pulse, latched into status bit 4 |
| ctrl_word | output | 16 | Current value of control register 0 |
| xctrl_word | output | 16 | Current value of extended control register 16 |

## Verification
The assertions take for granted three things about the inputs:

- Event pulses are synchronous to the management clock.
- The straps are steady around reset release.
- Reset is asserted from time zero, so nothing is checked before the first address capture.

The stimulus changes the data line, the event inputs and reset only on falling clock edges, and it samples the driven line there as well. Each event is a single-period pulse. Reset is held for several clock periods with the straps already settled.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 5;

    typedef enum logic [2:0] {
        ST_PRE,
        ST_START,
        ST_OP,
        ST_ADDR,
        ST_TA,
        ST_WDATA,
        ST_RDATA
    } mf_state_e;

    // register addresses decoded by the station manager
    localparam logic [ADDR_W-1:0] RA_CTRL  = 5'd0;
    localparam logic [ADDR_W-1:0] RA_STAT  = 5'd1;
    localparam logic [ADDR_W-1:0] RA_ID1   = 5'd2;
    localparam logic [ADDR_W-1:0] RA_ID2   = 5'd3;
    localparam logic [ADDR_W-1:0] RA_XCTRL = 5'd16;

    // control bits 14:8 after reset: speed and auto-negotiation enable
    localparam logic [6:0] CTRL_DEF = 7'b011_0000;

endpackage

// File: rtl/mdio_frame_rx.sv
`timescale 1ns/1ps
module mdio_frame_rx
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdio_i,
    input  logic [ADDR_W-1:0] my_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_req,
    output logic              rd_done,
    output logic              wr_req,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int CW = $clog2(PRE_LEN + 1);
    localparam logic [CW-1:0] PRE_MAX  = CW'(PRE_LEN);
    localparam logic [CW-1:0] LAST_TWO = CW'(1);
    localparam logic [CW-1:0] LAST_ADR = CW'(2*ADDR_W - 1);
    localparam logic [CW-1:0] LAST_DAT = CW'(DATA_W - 1);

    mf_state_e         state, nxt;
    logic [CW-1:0]     cnt, nxt_cnt;
    logic [DATA_W-2:0] sh;
    logic              op_rd;
    logic [ADDR_W-1:0] reg_q;
    logic [DATA_W-1:0] tx;
    logic              oe_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_PRE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= nxt_cnt;
        end
    end

    // next state and bit counter
    always_comb begin
        nxt     = state;
        nxt_cnt = cnt + CW'(1);
        unique case (state)
            ST_PRE: begin
                if (mdio_i) begin
                    nxt_cnt = (cnt == PRE_MAX) ? cnt : cnt + CW'(1);
                end else if (cnt == PRE_MAX) begin
                    nxt     = ST_START;
                    nxt_cnt = '0;
                end else begin
                    nxt_cnt = '0;
                end
            end
            ST_START: begin
                nxt     = mdio_i ? ST_OP : ST_PRE;
                nxt_cnt = '0;
            end
            ST_OP: begin
                if (cnt == LAST_TWO) begin
                    nxt_cnt = '0;
                    if ({sh[0], mdio_i} == 2'b10 || {sh[0], mdio_i} == 2'b01)
                        nxt = ST_ADDR;
                    else
                        nxt = ST_PRE;
                end
            end
            ST_ADDR: begin
                if (cnt == LAST_ADR) begin
                    nxt_cnt = '0;
                    nxt     = (sh[8:4] == my_addr) ? ST_TA : ST_PRE;
                end
            end
            ST_TA: begin
                if (cnt == LAST_TWO) begin
                    nxt_cnt = '0;
                    nxt     = op_rd ? ST_RDATA : ST_WDATA;
                end
            end
            ST_WDATA, ST_RDATA: begin
                if (cnt == LAST_DAT) begin
                    nxt_cnt = '0;
                    nxt     = ST_PRE;
                end
            end
            default: begin
                nxt     = ST_PRE;
                nxt_cnt = '0;
            end
        endcase
    end

    // input shifter and captured frame fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh    <= '0;
            op_rd <= 1'b0;
            reg_q <= '0;
        end else begin
            sh <= {sh[DATA_W-3:0], mdio_i};
            if (state == ST_OP && cnt == LAST_TWO)
                op_rd <= sh[0] & ~mdio_i;
            if (state == ST_ADDR && cnt == LAST_ADR)
                reg_q <= {sh[3:0], mdio_i};
        end
    end

    assign rd_req  = (state == ST_TA) && (cnt == LAST_TWO) && op_rd;
    assign rd_done = (state == ST_RDATA) && (cnt == LAST_DAT);
    assign wr_req  = (state == ST_WDATA) && (cnt == LAST_DAT);
    assign wr_data = {sh, mdio_i};
    assign reg_addr = reg_q;

    // output process: read shifter and driver enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx   <= '0;
            oe_q <= 1'b0;
        end else if (rd_req) begin
            tx   <= rd_data;
            oe_q <= 1'b1;
        end else if (state == ST_RDATA) begin
            tx <= {tx[DATA_W-2:0], 1'b0};
            if (cnt == LAST_DAT)
                oe_q <= 1'b0;
        end
    end

    assign mdio_o  = tx[DATA_W-1];
    assign mdio_oe = oe_q;

endmodule

// File: rtl/mdio_reg_bank.sv
`timescale 1ns/1ps
module mdio_reg_bank
    import mdio_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_HI = 16'h0282,
    parameter logic [DATA_W-1:0] ID_LO = 16'hF013,
    parameter logic [4:0]        ABIL  = 5'b01111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              rd_req,
    input  logic              rd_done,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ev_jabber,
    input  logic              ev_remote_fault,
    output logic [ADDR_W-1:0] my_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [DATA_W-1:0] xctrl_word,
    output logic [DATA_W-1:0] stat_word
);

    logic              captured;
    logic [ADDR_W-1:0] addr_q;
    logic [6:0]        ctl_q;
    logic              ovr_q;
    logic              alt_q;
    logic [DATA_W-1:0] id1_q, id2_q;
    logic [1:0]        lh_q;
    logic [1:0]        pend_q;
    logic [1:0]        ev;

    assign ev = {ev_remote_fault, ev_jabber};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            captured <= 1'b0;
            addr_q   <= '0;
            ctl_q    <= CTRL_DEF;
            ovr_q    <= 1'b0;
            alt_q    <= 1'b0;
            id1_q    <= ID_HI;
            id2_q    <= ID_LO;
            lh_q     <= '0;
            pend_q   <= '0;
        end else begin
            lh_q   <= lh_q | ev;
            pend_q <= pend_q | ev;
            if (!captured) begin
                captured <= 1'b1;
                addr_q   <= strap_addr;
                ctl_q[2] <= (strap_addr == '0);
            end
            if (rd_req && reg_addr == RA_STAT)
                pend_q <= ev;
            if (rd_done && reg_addr == RA_STAT)
                lh_q <= pend_q | ev;
            if (wr_req) begin
                case (reg_addr)
                    RA_CTRL: begin
                        if (wr_data[15]) begin
                            ctl_q    <= CTRL_DEF;
                            ctl_q[2] <= (addr_q == '0);
                            ovr_q    <= 1'b0;
                            alt_q    <= 1'b0;
                            id1_q    <= ID_HI;
                            id2_q    <= ID_LO;
                            lh_q     <= ev;
                            pend_q   <= ev;
                        end else begin
                            ctl_q <= wr_data[14:8];
                        end
                    end
                    RA_ID1:   if (ovr_q) id1_q <= wr_data;
                    RA_ID2:   if (ovr_q) id2_q <= wr_data;
                    RA_XCTRL: begin
                        ovr_q <= wr_data[15];
                        alt_q <= wr_data[3];
                    end
                    default: ;
                endcase
            end
        end
    end

    assign my_addr    = addr_q;
    assign ctrl_word  = {1'b0, ctl_q, 8'h00};
    assign xctrl_word = {ovr_q, 4'b0000, addr_q, 2'b00, alt_q, 3'b000};
    assign stat_word  = {ABIL, 6'b000000, lh_q[1], 1'b1, 1'b0, lh_q[0], 1'b1};

    always_comb begin
        unique case (reg_addr)
            RA_CTRL:  rd_data = ctrl_word;
            RA_STAT:  rd_data = stat_word;
            RA_ID1:   rd_data = id1_q;
            RA_ID2:   rd_data = id2_q;
            RA_XCTRL: rd_data = xctrl_word;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/mdio_mgmt_slave.sv
`timescale 1ns/1ps
module mdio_mgmt_slave
    import mdio_pkg::*;
#(
    parameter int                PRE_LEN = 32,
    parameter logic [DATA_W-1:0] ID_HI   = 16'h0282,
    parameter logic [DATA_W-1:0] ID_LO   = 16'hF013,
    parameter logic [4:0]        ABIL    = 5'b01111
) (
    input  logic        mdc,
    input  logic        rst_n,
    input  logic [4:0]  strap_addr,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        ev_jabber,
    input  logic        ev_remote_fault,
    output logic [15:0] ctrl_word,
    output logic [15:0] xctrl_word
);

    logic              rd_req, rd_done, wr_req;
    logic [ADDR_W-1:0] reg_addr, my_addr;
    logic [DATA_W-1:0] wr_data, rd_data, stat_word;

    mdio_frame_rx #(.PRE_LEN(PRE_LEN)) u_rx (
        .clk      (mdc),
        .rst_n    (rst_n),
        .mdio_i   (mdio_i),
        .my_addr  (my_addr),
        .rd_data  (rd_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_req   (rd_req),
        .rd_done  (rd_done),
        .wr_req   (wr_req),
        .reg_addr (reg_addr),
        .wr_data  (wr_data)
    );

    mdio_reg_bank #(.ID_HI(ID_HI), .ID_LO(ID_LO), .ABIL(ABIL)) u_regs (
        .clk             (mdc),
        .rst_n           (rst_n),
        .strap_addr      (strap_addr),
        .rd_req          (rd_req),
        .rd_done         (rd_done),
        .wr_req          (wr_req),
        .reg_addr        (reg_addr),
        .wr_data         (wr_data),
        .ev_jabber       (ev_jabber),
        .ev_remote_fault (ev_remote_fault),
        .my_addr         (my_addr),
        .rd_data         (rd_data),
        .ctrl_word       (ctrl_word),
        .xctrl_word      (xctrl_word),
        .stat_word       (stat_word)
    );

endmodule

// File: rtl/mdio_mgmt_checker.sv
`timescale 1ns/1ps
module mdio_mgmt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mdio_oe,
    input logic       rd_req,
    input logic       rd_done,
    input logic       wr_req,
    input logic [4:0] reg_addr,
    input logic       wr_bit15,
    input logic       ev_jabber,
    input logic       jab_bit,
    input logic [4:0] addr_field
);

    logic [1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cyc <= 2'd0;
        else if (cyc != 2'd3)
            cyc <= cyc + 2'd1;
    end

    // R4: driver turns on only after a read turnaround completes
    a_r4_drive_after_ta: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> $past(rd_req));

    // R4: line released after the last data bit
    a_r4_release_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !mdio_oe);

    // R1: no write is accepted while the block drives the line
    a_r1_no_write_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !mdio_oe);

    // R5: captured address never moves after capture
    a_r5_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2) |-> $stable(addr_field));

    // R9: a jabber event is visible in the status bit on the next cycle
    a_r9_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_jabber |=> jab_bit);

    // R9: the status bit clears only at a completed status read or a software reset
    a_r9_clear_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(jab_bit) |-> $past((rd_done && reg_addr == 5'd1) ||
                                 (wr_req && reg_addr == 5'd0 && wr_bit15)));

endmodule

bind mdio_mgmt_slave mdio_mgmt_checker u_chk (
    .clk        (mdc),
    .rst_n      (rst_n),
    .mdio_oe    (mdio_oe),
    .rd_req     (rd_req),
    .rd_done    (rd_done),
    .wr_req     (wr_req),
    .reg_addr   (reg_addr),
    .wr_bit15   (wr_data[15]),
    .ev_jabber  (ev_jabber),
    .jab_bit    (stat_word[1]),
    .addr_field (xctrl_word[10:6])
);

// File: tb/mdio_mgmt_slave_test.sv
`timescale 1ns/1ps
module mdio_mgmt_slave_test;

    localparam logic [15:0] IDH = 16'h0282;
    localparam logic [15:0] IDL = 16'hF013;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  strap = 5'd3;
    logic        mdio_in = 1'b1;
    logic        ev_jab = 1'b0;
    logic        ev_rf = 1'b0;
    logic        mdio_o, mdio_oe;
    logic [15:0] ctrl_word, xctrl_word;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mdio_mgmt_slave uut (
        .mdc             (clk),
        .rst_n           (rst_n),
        .strap_addr      (strap),
        .mdio_i          (mdio_in),
        .mdio_o          (mdio_o),
        .mdio_oe         (mdio_oe),
        .ev_jabber       (ev_jab),
        .ev_remote_fault (ev_rf),
        .ctrl_word       (ctrl_word),
        .xctrl_word      (xctrl_word)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put_bit(input logic b);
        @(negedge clk);
        mdio_in = b;
    endtask

    task automatic preamble(input int n);
        for (int i = 0; i < n; i++) put_bit(1'b1);
    endtask

    task automatic put_field(input logic [15:0] v, input int w);
        for (int i = w - 1; i >= 0; i--) put_bit(v[i]);
    endtask

    task automatic do_write(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
        preamble(32);
        put_field(16'b0101, 4);
        put_field({11'd0, phy}, 5);
        put_field({11'd0, ra}, 5);
        put_field(16'b10, 2);
        put_field(d, 16);
        put_bit(1'b1);
    endtask

    // read frame; ev_slot >= 0 pulses the jabber input in that data slot
    task automatic do_read(input logic [4:0] phy, input logic [4:0] ra, input int ev_slot,
                           output logic [15:0] val, output int drove);
        int ta_on;
        preamble(32);
        put_field(16'b0110, 4);
        put_field({11'd0, phy}, 5);
        put_field({11'd0, ra}, 5);
        ta_on = 0;
        for (int i = 0; i < 2; i++) begin
            put_bit(1'b1);
            if (mdio_oe) ta_on++;
        end
        check("R4 driver off in turnaround", 16'(ta_on), 16'd0);
        drove = 0;
        val = '0;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            ev_jab = (k == ev_slot);
            if (mdio_oe) drove++;
            val[15-k] = mdio_o;
        end
        @(negedge clk);
        ev_jab = 1'b0;
        if (mdio_oe) drove += 100;
    endtask

    task automatic read_chk(input string tag, input logic [4:0] phy, input logic [4:0] ra,
                            input logic [15:0] exp);
        logic [15:0] v;
        int dr;
        do_read(phy, ra, -1, v, dr);
        check({tag, " drive window"}, 16'(dr), 16'd16);
        check(tag, v, exp);
    endtask

    task automatic pulse(input bit jab, input bit rf);
        @(negedge clk);
        ev_jab = jab;
        ev_rf = rf;
        @(negedge clk);
        ev_jab = 1'b0;
        ev_rf = 1'b0;
    endtask

    task automatic do_reset(input logic [4:0] s);
        @(negedge clk);
        rst_n = 1'b0;
        strap = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_state;
        check("R6 ctrl default, addr 3", ctrl_word, 16'h3000);
        check("R5 address field", xctrl_word, 16'h00C0);
        check("R11 bit15 zero after hw reset", {15'd0, ctrl_word[15]}, 16'd0);
        read_chk("R5 read reg16", 5'd3, 5'd16, 16'h00C0);
        read_chk("R2 read reg0", 5'd3, 5'd0, 16'h3000);
    endtask

    task automatic t_ctrl_write;
        do_write(5'd3, 5'd0, 16'h41FF);
        read_chk("R8 ctrl reserved low bits", 5'd3, 5'd0, 16'h4100);
        check("R12 ctrl output", ctrl_word, 16'h4100);
    endtask

    task automatic t_other_addr;
        logic [15:0] v;
        int dr;
        do_write(5'd5, 5'd0, 16'h0000);
        check("R1 foreign write ignored", ctrl_word, 16'h4100);
        do_read(5'd5, 5'd0, -1, v, dr);
        check("R1 foreign read not driven", 16'(dr), 16'd0);
    endtask

    task automatic t_bad_frames;
        // bad start 0,0
        preamble(32);
        put_field(16'b0001, 4);
        put_field({6'd0, 5'd3, 5'd0}, 10);
        put_field(16'b10, 2);
        put_field(16'h0800, 16);
        check("R3 bad start ignored", ctrl_word, 16'h4100);
        // bad opcode 1,1
        preamble(32);
        put_field(16'b0111, 4);
        put_field({6'd0, 5'd3, 5'd0}, 10);
        put_field(16'b10, 2);
        put_field(16'h0800, 16);
        check("R3 bad opcode ignored", ctrl_word, 16'h4100);
        // short preamble after a zero
        put_bit(1'b0);
        preamble(20);
        put_field(16'b0101, 4);
        put_field({6'd0, 5'd3, 5'd0}, 10);
        put_field(16'b10, 2);
        put_field(16'h0800, 16);
        check("R3 short preamble ignored", ctrl_word, 16'h4100);
        read_chk("R3 valid frame after bad ones", 5'd3, 5'd0, 16'h4100);
    endtask

    task automatic t_ident;
        read_chk("R7 id1 read", 5'd3, 5'd2, IDH);
        do_write(5'd3, 5'd2, 16'hAAAA);
        read_chk("R7 id1 locked", 5'd3, 5'd2, IDH);
        do_write(5'd3, 5'd16, 16'h8000);
        read_chk("R7 override set", 5'd3, 5'd16, 16'h80C0);
        do_write(5'd3, 5'd2, 16'hAAAA);
        do_write(5'd3, 5'd3, 16'h5555);
        read_chk("R7 id1 written", 5'd3, 5'd2, 16'hAAAA);
        read_chk("R7 id2 written", 5'd3, 5'd3, 16'h5555);
        do_write(5'd3, 5'd16, 16'h7FFF);
        read_chk("R8 reg16 reserved and addr", 5'd3, 5'd16, 16'h00C8);
        check("R12 xctrl output", xctrl_word, 16'h00C8);
        do_write(5'd3, 5'd2, 16'h1111);
        read_chk("R7 id1 relocked", 5'd3, 5'd2, 16'hAAAA);
    endtask

    task automatic t_unimpl;
        do_write(5'd3, 5'd7, 16'hFFFF);
        read_chk("R8 unmapped reg", 5'd3, 5'd7, 16'h0000);
        do_write(5'd3, 5'd1, 16'hFFFF);
        read_chk("R8 status not writable", 5'd3, 5'd1, 16'h7809);
    endtask

    task automatic t_latch;
        logic [15:0] v;
        int dr;
        pulse(1'b1, 1'b0);
        read_chk("R9 jabber latched", 5'd3, 5'd1, 16'h780B);
        read_chk("R9 jabber cleared by read", 5'd3, 5'd1, 16'h7809);
        pulse(1'b0, 1'b1);
        repeat (40) @(negedge clk);
        read_chk("R9 fault held", 5'd3, 5'd1, 16'h7819);
        read_chk("R9 fault cleared", 5'd3, 5'd1, 16'h7809);
        do_read(5'd3, 5'd1, 6, v, dr);
        check("R10 snapshot before event", v, 16'h7809);
        read_chk("R10 event during read kept", 5'd3, 5'd1, 16'h780B);
        read_chk("R10 cleared after next read", 5'd3, 5'd1, 16'h7809);
    endtask

    task automatic t_soft_reset;
        do_write(5'd3, 5'd16, 16'h8008);
        do_write(5'd3, 5'd0, 16'h8000);
        read_chk("R11 ctrl defaults", 5'd3, 5'd0, 16'h3000);
        read_chk("R11 reg16 defaults", 5'd3, 5'd16, 16'h00C0);
        read_chk("R11 id restored", 5'd3, 5'd2, IDH);
        read_chk("R11 id2 restored", 5'd3, 5'd3, IDL);
    endtask

    task automatic t_addr_zero;
        do_reset(5'd0);
        check("R6 isolate with address 0", ctrl_word, 16'h3400);
        check("R5 address 0 field", xctrl_word, 16'h0000);
        read_chk("R1 address 0 responds", 5'd0, 5'd0, 16'h3400);
        do_write(5'd0, 5'd0, 16'h0000);
        do_write(5'd0, 5'd0, 16'h8000);
        read_chk("R11 isolate default kept", 5'd0, 5'd0, 16'h3400);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset_state();
        t_ctrl_write();
        t_other_addr();
        t_bad_frames();
        t_ident();
        t_unimpl();
        t_latch();
        t_soft_reset();
        t_addr_zero();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule